// File: doc/BRIEF.md
# Mixed-Precision Bit-Slice Shift Accumulator

This block assembles full-precision dot-product results from partial dot products computed on narrow operand slices. Both operand precisions are runtime settings. The first operand, called A, is cut into slices of a configurable width `w`. One A slice is presented per pass. Each pass is weighted by `2^(w*t)` and summed into an accumulator. The second operand, called B, is cut into 4-bit slices. Each B slice sits in its own lane. A local reduction shifts each lane left by four bits per lane position and adds the lanes of a group together.

The B precision sets the group size. A result needs `ceil(Bprec/4)` lanes, and this count is rounded up to a power of two to give the group size. The lanes that are left over then hold further groups, and each group produces an independent result. With eight lanes, 4-bit B gives eight results per pass sequence and 8-bit B gives four. Lowering the A precision cuts the number of passes in the same proportion.

The upstream slice multipliers treat the top A slice and the top B slice as signed and all other slices as unsigned. This block extends each lane value to match that convention.

Top module: `mpsa_shift_accum`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0 and every `result_o` slot is 0.
- R2: With `n = ceil(b_prec_i/4)` and `G` the smallest power of two that is at least `n`, lanes `g*G .. g*G+G-1` form group `g`. The lane at offset `m` inside a group is shifted left by `4*m` bits, and the group's reduced sum feeds `result_o` slot `g`.
- R3: A lane at group offset `m >= n` contributes zero, whatever its `lane_prod_i` value.
- R4: The lane at group offset `n-1` is sign-extended from `PROD_W` bits. Lower lanes are zero-extended unless the pass is the last one.
- R5: Pass `t` (counted from 0 since the previous output) is shifted left by `slice_w_i*t`. On the pass flagged by `last_i`, every lane is sign-extended.
- R6: The first valid pass of each output replaces the accumulator contents, so earlier outputs have no effect on the new one.
- R7: `done_o` is 1 for exactly the cycle after each clock edge that takes a pass with `last_i`. `result_o` stays unchanged on cycles with `valid_i` low.
- R8: Only slots `0 .. NUM_LANES/G-1` carry results. The remaining slots read 0 when `done_o` is 1.
- R9: For A and B precisions from 2 to 32 and slice widths from 1 to 8, each used slot equals the signed sum over k of `A[k]*B_g[k]`, taken modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| b_prec_i | input | 6 | Precision of B in bits (2..32) |
| slice_w_i | input | 4 | Width of the A slice per pass (1..8) |
| valid_i | input | 1 | A pass is presented this cycle |
| last_i | input | 1 | This pass carries the top A slice |
| lane_prod_i | input | 8x16 | Partial dot product per lane, one A slice times one B slice |
| done_o | output | 1 | Results complete, one-cycle pulse |
| result_o | output | 8x64 | Accumulated signed result per output slot |

## Verification
The assertions assume three things about the inputs. The precision fields stay constant from the first pass of an output to its last. The pass index times the slice width stays below 32. Upstream values fit in 16 bits: unsigned for slice products without a top slice, two's complement otherwise. The bench generates operands as exact two's complement numbers of the chosen precision and slices them the same way the upstream multipliers would. It sums 16 pairs per lane, so unsigned lane values can exceed 2^15 and make the choice between sign and zero extension visible. It raises `last_i` exactly at pass `ceil(Aprec/w)-1`, and it changes the configuration only between outputs.

// File: rtl/mpsa_pkg.sv
package mpsa_pkg;

  function automatic int unsigned lanes_needed(int unsigned prec);
    return (prec + 3) / 4;
  endfunction

  function automatic int unsigned ceil_log2(int unsigned n);
    int unsigned l;
    l = 0;
    for (int i = 0; i < 8; i++) begin
      if ((32'd1 << l) < n) l = l + 1;
    end
    return l;
  endfunction

endpackage

// File: rtl/mpsa_lane_cond.sv
module mpsa_lane_cond #(
  parameter int NUM_LANES = 8,
  parameter int LANE_IDX  = 0,
  parameter int PROD_W    = 16,
  parameter int ACC_W     = 64,
  parameter int LW        = 3,
  parameter int CNT_W     = 4,
  parameter int GL_W      = 2
) (
  input  logic [PROD_W-1:0] lane_prod_i,
  input  logic [CNT_W-1:0]  n_act_i,
  input  logic [GL_W-1:0]   grp_log2_i,
  input  logic              last_pass_i,
  output logic [ACC_W-1:0]  term_o
);

  logic [LW-1:0]    mask;
  logic [LW-1:0]    ofs;
  logic             active;
  logic             top;
  logic             sgn;
  logic [ACC_W-1:0] ext;

  always_comb begin
    mask   = ~({LW{1'b1}} << grp_log2_i);
    ofs    = LW'(LANE_IDX) & mask;
    active = {1'b0, ofs} < n_act_i;
    top    = {1'b0, ofs} == (n_act_i - CNT_W'(1));
    // top B slice or top A slice carries a sign
    sgn    = top | last_pass_i;
    ext    = {{(ACC_W-PROD_W){sgn & lane_prod_i[PROD_W-1]}}, lane_prod_i};
    term_o = active ? (ext << {ofs, 2'b00}) : '0;
  end

endmodule

// File: rtl/mpsa_group_reduce.sv
module mpsa_group_reduce #(
  parameter int NUM_LANES = 8,
  parameter int ACC_W     = 64,
  parameter int LW        = 3,
  parameter int GL_W      = 2
) (
  input  logic [ACC_W-1:0] term_i [NUM_LANES],
  input  logic [GL_W-1:0]  grp_log2_i,
  output logic [ACC_W-1:0] sum_o  [NUM_LANES]
);

  logic [ACC_W-1:0] lvl [LW+1][NUM_LANES];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lvl0
    assign lvl[0][i] = term_i[i];
  end

  for (genvar l = 1; l <= LW; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_node
      if (i < (NUM_LANES >> l)) begin : g_add
        assign lvl[l][i] = lvl[l-1][2*i] + lvl[l-1][2*i+1];
      end else begin : g_pad
        assign lvl[l][i] = '0;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_LANES; k++) begin
      sum_o[k] = lvl[grp_log2_i][k];
    end
  end

endmodule

// File: rtl/mpsa_accum_slot.sv
module mpsa_accum_slot #(
  parameter int ACC_W   = 64,
  parameter int SHAMT_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               first_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [ACC_W-1:0]   sum_i,
  output logic [ACC_W-1:0]   acc_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] addend;

  always_comb begin
    base   = first_i ? '0 : acc_q;
    addend = sum_i << shamt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (valid_i) begin
      acc_q <= base + addend;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/mpsa_shift_accum.sv
module mpsa_shift_accum #(
  parameter int MAX_PREC    = 32,
  parameter int MAX_SLICE_W = 8,
  parameter int PROD_W      = 16,
  parameter int ACC_W       = 64,
  localparam int NUM_LANES  = MAX_PREC / 4,
  localparam int PREC_W     = $clog2(MAX_PREC + 1),
  localparam int SW_W       = $clog2(MAX_SLICE_W + 1)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [PREC_W-1:0]                   b_prec_i,
  input  logic [SW_W-1:0]                     slice_w_i,
  input  logic                                valid_i,
  input  logic                                last_i,
  input  logic [NUM_LANES-1:0][PROD_W-1:0]    lane_prod_i,
  output logic                                done_o,
  output logic [NUM_LANES-1:0][ACC_W-1:0]     result_o
);

  localparam int LW      = $clog2(NUM_LANES);
  localparam int CNT_W   = LW + 1;
  localparam int GL_W    = (LW > 0) ? $clog2(LW + 1) : 1;
  localparam int PASS_W  = $clog2(MAX_PREC);
  localparam int SHAMT_W = SW_W + PASS_W;

  logic [CNT_W-1:0]   n_act;
  logic [GL_W-1:0]    grp_log2;
  logic [PASS_W-1:0]  pass_q;
  logic               first;
  logic [SHAMT_W-1:0] shamt;
  logic               done_q;
  logic [ACC_W-1:0]   term [NUM_LANES];
  logic [ACC_W-1:0]   grp_sum [NUM_LANES];

  always_comb begin
    n_act    = CNT_W'(mpsa_pkg::lanes_needed(32'(b_prec_i)));
    grp_log2 = GL_W'(mpsa_pkg::ceil_log2(32'(n_act)));
    first    = (pass_q == '0);
    shamt    = SHAMT_W'(slice_w_i) * SHAMT_W'(pass_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= valid_i & last_i;
      if (valid_i) pass_q <= last_i ? '0 : pass_q + PASS_W'(1);
    end
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    mpsa_lane_cond #(
      .NUM_LANES (NUM_LANES),
      .LANE_IDX  (j),
      .PROD_W    (PROD_W),
      .ACC_W     (ACC_W),
      .LW        (LW),
      .CNT_W     (CNT_W),
      .GL_W      (GL_W)
    ) i_lane_cond (
      .lane_prod_i (lane_prod_i[j]),
      .n_act_i     (n_act),
      .grp_log2_i  (grp_log2),
      .last_pass_i (last_i),
      .term_o      (term[j])
    );
  end

  mpsa_group_reduce #(
    .NUM_LANES (NUM_LANES),
    .ACC_W     (ACC_W),
    .LW        (LW),
    .GL_W      (GL_W)
  ) i_group_reduce (
    .term_i     (term),
    .grp_log2_i (grp_log2),
    .sum_o      (grp_sum)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_slot
    mpsa_accum_slot #(
      .ACC_W   (ACC_W),
      .SHAMT_W (SHAMT_W)
    ) i_accum_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i),
      .first_i (first),
      .shamt_i (shamt),
      .sum_i   (grp_sum[k]),
      .acc_o   (result_o[k])
    );
  end

  assign done_o = done_q;

endmodule

// File: rtl/mpsa_checker.sv
module mpsa_checker #(
  parameter int NUM_LANES = 8,
  parameter int MAX_PREC  = 32,
  parameter int ACC_W     = 64,
  parameter int PREC_W    = 6,
  parameter int SW_W      = 4
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [PREC_W-1:0]               b_prec_i,
  input logic [SW_W-1:0]                 slice_w_i,
  input logic                            valid_i,
  input logic                            last_i,
  input logic                            done_o,
  input logic [NUM_LANES-1:0][ACC_W-1:0] result_o
);

  logic [PREC_W-1:0] cnt_q;
  int n_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i) cnt_q <= last_i ? '0 : cnt_q + PREC_W'(1);
  end

  always_comb begin
    int na;
    int gs;
    na = (int'(b_prec_i) + 3) / 4;
    gs = 1;
    for (int i = 0; i <= $clog2(NUM_LANES); i++) begin
      if (gs < na) gs = gs * 2;
    end
    n_out = NUM_LANES / gs;
  end

  // input assumption: pass offset stays inside the operand range (R5)
  p_pass_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (int'(cnt_q) * int'(slice_w_i)) < MAX_PREC)
    else $error("pass offset beyond operand width");

  // input assumption: configuration held across one output (R6)
  p_cfg_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> ($stable(b_prec_i) && $stable(slice_w_i)))
    else $error("configuration changed mid-output");

  p_done_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i) |=> done_o)
    else $error("done missing after last pass");

  p_no_spurious_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && last_i) |=> !done_o)
    else $error("done without last pass");

  p_hold_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o))
    else $error("result moved while idle");

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_slot_chk
    p_unused_slot_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && (k >= n_out)) |-> (result_o[k] == '0))
      else $error("unused slot not zero");
  end

endmodule

bind mpsa_shift_accum mpsa_checker #(
  .NUM_LANES (NUM_LANES),
  .MAX_PREC  (MAX_PREC),
  .ACC_W     (ACC_W),
  .PREC_W    (PREC_W),
  .SW_W      (SW_W)
) i_mpsa_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .b_prec_i  (b_prec_i),
  .slice_w_i (slice_w_i),
  .valid_i   (valid_i),
  .last_i    (last_i),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/test_mpsa_shift_accum.sv
`timescale 1ns/1ps
module test_mpsa_shift_accum;

  localparam int NL = 8;
  localparam int PW = 16;
  localparam int AW = 64;
  localparam int K  = 16;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [5:0]             b_prec_i = 6'd8;
  logic [3:0]             slice_w_i = 4'd4;
  logic                   valid_i = 1'b0;
  logic                   last_i = 1'b0;
  logic [NL-1:0][PW-1:0]  lane_prod_i = '0;
  logic                   done_o;
  logic [NL-1:0][AW-1:0]  result_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  longint a_v [K];
  longint b_v [NL][K];
  longint ref_v [NL];
  logic [NL-1:0][AW-1:0] held;

  always #2.5 clk_i = ~clk_i;

  mpsa_shift_accum i_mpsa_shift_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .b_prec_i    (b_prec_i),
    .slice_w_i   (slice_w_i),
    .valid_i     (valid_i),
    .last_i      (last_i),
    .lane_prod_i (lane_prod_i),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  function automatic longint sx(longint v, int p);
    longint m;
    m = (64'sd1 <<< p) - 1;
    v = v & m;
    if (v[p-1]) v = v - (64'sd1 <<< p);
    return v;
  endfunction

  function automatic longint gen_op(int p, int mode);
    case (mode)
      1:       return -(64'sd1 <<< (p-1));
      2:       return (64'sd1 <<< (p-1)) - 1;
      3:       return -64'sd1;
      default: return sx(longint'({$urandom, $urandom}), p);
    endcase
  endfunction

  function automatic longint slice_of(longint v, int w, int idx, bit top);
    longint s;
    s = (v >>> (w*idx)) & ((64'sd1 <<< w) - 1);
    if (top && s[w-1]) s = s - (64'sd1 <<< w);
    return s;
  endfunction

  task automatic chk(string tag, longint got, longint exp, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic run_op(int ap, int bp, int w, int amode, int bmode, bit garbage, string tag);
    int nact, gs, nout, np;
    nact = (bp + 3) / 4;
    gs = 1;
    while (gs < nact) gs = gs * 2;
    nout = NL / gs;
    np = (ap + w - 1) / w;
    for (int k = 0; k < K; k++) a_v[k] = gen_op(ap, amode);
    for (int g = 0; g < NL; g++) begin
      ref_v[g] = 0;
      for (int k = 0; k < K; k++) begin
        b_v[g][k] = gen_op(bp, bmode);
        ref_v[g] = ref_v[g] + a_v[k] * b_v[g][k];
      end
    end
    for (int t = 0; t < np; t++) begin
      @(negedge clk_i);
      b_prec_i  = 6'(bp);
      slice_w_i = 4'(w);
      valid_i   = 1'b1;
      last_i    = (t == np - 1);
      for (int g = 0; g < nout; g++) begin
        for (int m = 0; m < gs; m++) begin
          longint v;
          v = 0;
          if (m < nact) begin
            for (int k = 0; k < K; k++)
              v = v + slice_of(a_v[k], w, t, t == np - 1) * slice_of(b_v[g][k], 4, m, m == nact - 1);
            lane_prod_i[g*gs+m] = v[PW-1:0];
          end else begin
            lane_prod_i[g*gs+m] = garbage ? PW'($urandom) : '0;
          end
        end
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    last_i  = 1'b0;
    for (int j = 0; j < NL; j++) lane_prod_i[j] = PW'($urandom);
    chk("R7", longint'(done_o), 1, "done after last pass");
    for (int s = 0; s < NL; s++) begin
      if (s < nout) chk(tag, longint'(result_o[s]), ref_v[s], $sformatf("slot %0d", s));
      else          chk("R8", longint'(result_o[s]), 0, $sformatf("unused slot %0d", s));
    end
    held = result_o;
    @(negedge clk_i);
    chk("R7", longint'(done_o), 0, "done one cycle only");
    chk("R7", (result_o === held) ? 1 : 0, 1, "result held while idle");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #500us;
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    chk("R1", longint'(done_o), 0, "done in reset");
    chk("R1", (result_o == '0) ? 1 : 0, 1, "results in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", longint'(done_o), 0, "done after reset");
    chk("R1", (result_o == '0) ? 1 : 0, 1, "results after reset");

    run_op(8, 8, 4, 0, 0, 1'b0, "R2");
    run_op(8, 4, 8, 0, 0, 1'b0, "R2");
    run_op(6, 32, 2, 0, 0, 1'b0, "R2");
    run_op(12, 10, 4, 0, 0, 1'b1, "R3");
    run_op(5, 20, 3, 0, 0, 1'b1, "R3");
    run_op(16, 8, 8, 3, 3, 1'b0, "R4");
    run_op(8, 12, 8, 3, 2, 1'b0, "R4");
    run_op(32, 16, 1, 1, 2, 1'b0, "R5");
    run_op(32, 32, 8, 1, 1, 1'b0, "R5");
    run_op(7, 7, 3, 2, 1, 1'b1, "R5");
    run_op(16, 16, 4, 2, 2, 1'b0, "R6");
    run_op(4, 4, 4, 0, 0, 1'b0, "R6");
    run_op(2, 2, 2, 1, 1, 1'b0, "R9");
    run_op(32, 32, 1, 0, 0, 1'b1, "R9");

    for (int i = 0; i < 80; i++) begin
      run_op(2 + int'($urandom_range(30)), 2 + int'($urandom_range(30)),
             1 + int'($urandom_range(7)), 0, 0, 1'($urandom), "R9");
    end

    fin = 1'b1;
    summary();
    $finish;
  end

endmodule